// File: doc/BRIEF.md
# ECC Fault Control Register Bank

This block is the software-visible register bank that sits beside an ECC memory controller's fault-reporting logic. It holds eight 32-bit words in a 32-byte window:

- a fault control word
- a fault status word
- two fault-address words
- a diagnostic word
- three spare words

Only the low five address bits are decoded, so the window repeats through whatever larger region it is mapped into. Apart from the control word, every word is plain storage: software writes a full word and reads the same value back. Error detection, syndrome logic and interrupt generation live elsewhere.

The top eight bits of the control word are an identity field: a version nibble in bits [27:24] and an implementation nibble in bits [31:28]. The field is fixed by a strap parameter. Software writes cannot alter it, and reset does not clear it. Bit 0 of the control word enables ECC checking and bit 4 enables correctable-error interrupts. Both bits are ordinary writable storage here.

Every request is answered one clock later with a one-cycle ready pulse. Only full-word accesses act on the bank. Byte and halfword writes are dropped, and byte and halfword reads return zero.

Top module: `ecc_fault_regbank`

## Requirements
- R1: Only address bits [4:2] select a word; bits [1:0] and all bits above bit 4 are ignored. The word map is: 0x00 control, 0x04 spare, 0x08 status, 0x0C spare, 0x10 address 0, 0x14 address 1, 0x18 diagnostic, 0x1C spare.
- R2: Control bits [31:24] always equal the IDENT parameter (version in [27:24], implementation in [31:28]). No write can change them.
- R3: A full-word write to offset 0x00 replaces control bits [23:0], including bit 0 (checking enable) and bit 4 (correctable interrupt enable).
- R4: The seven words at offsets 0x04 to 0x1C store any full-word write and return it unchanged on a full-word read.
- R5: The size encoding is 2'b00 byte, 2'b01 halfword and 2'b10 word. A write of byte or halfword size changes no register.
- R6: Read data is zero in the response to a byte or halfword read and in the response to any write.
- R7: Each request cycle (req_valid high) is answered by rsp_ready high for exactly the following cycle. rsp_ready is low after a cycle without a request.
- R8: A full-word read returns its data in the cycle after the request, together with rsp_ready. A read issued in the cycle right after a write sees the written value.
- R9: Reset is synchronous and active high. After a reset edge the control word is {IDENT, 24'h0}, the other seven words are zero, and rsp_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; bits [4:2] decoded |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word |
| req_wdata | input | REG_W | Write data |
| rsp_rdata | output | REG_W | Registered read data |
| rsp_ready | output | 1 | One-cycle reply pulse per request |

## Verification
All eight words are written with distinct values and read back. This separates a wrong word decode from a storage fault. Writes of all ones and of zero to the control word show whether the identity byte is masked while bits 0 and 4 still follow software. Each offset is accessed at two high aliases with different upper address bits, which exposes any decode of bits above bit 4. Byte and halfword writes carrying all-ones data are followed by full-word reads, and narrow reads are checked for zero, so any leak from a narrow access shows up. A reset after a full fill checks that the identity byte survives while everything else clears.

// File: rtl/ecc_regbank_pkg.sv
package ecc_regbank_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } acc_size_e;

  // Keep the bits selected by lock_mask from cur, take the rest from wr.
  function automatic logic [REG_W-1:0] merge_locked(
    input logic [REG_W-1:0] cur,
    input logic [REG_W-1:0] wr,
    input logic [REG_W-1:0] lock_mask
  );
    return (cur & lock_mask) | (wr & ~lock_mask);
  endfunction

  function automatic logic is_full_word(input logic [1:0] sz);
    return sz == SZ_WORD;
  endfunction
endpackage

// File: rtl/ecc_acc_decode.sv
module ecc_acc_decode
  import ecc_regbank_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NWORDS = 8,
  localparam int IDX_W = $clog2(NWORDS),
  localparam int LSB   = $clog2(REG_W / 8)
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output logic              wr_fire,
  output logic              rd_fire,
  output logic              narrow_wr,
  output logic [IDX_W-1:0]  word_idx
);
  logic full;

  always_comb begin
    full      = is_full_word(req_size);
    word_idx  = req_addr[LSB +: IDX_W];
    wr_fire   = req_valid && req_write && full;
    rd_fire   = req_valid && !req_write && full;
    narrow_wr = req_valid && req_write && !full;
  end
endmodule

// File: rtl/ecc_reg_store.sv
module ecc_reg_store
  import ecc_regbank_pkg::*;
#(
  parameter int NWORDS = 8,
  parameter int ID_W = 8,
  parameter logic [ID_W-1:0] IDENT = 8'h10,
  localparam int IDX_W = $clog2(NWORDS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_fire,
  input  logic [IDX_W-1:0]        word_idx,
  input  logic [REG_W-1:0]        wdata,
  output logic [NWORDS*REG_W-1:0] regs_flat
);
  localparam logic [REG_W-1:0] LOCK_MASK = {{ID_W{1'b1}}, {(REG_W-ID_W){1'b0}}};
  localparam logic [REG_W-1:0] CTRL_RST  = {IDENT, {(REG_W-ID_W){1'b0}}};

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic [REG_W-1:0] q;
    logic             hit;
    assign hit = wr_fire && (word_idx == IDX_W'(g));

    if (g == 0) begin : g_ctrl
      always_ff @(posedge clk) begin
        if (rst)      q <= CTRL_RST;
        else if (hit) q <= merge_locked(q, wdata, LOCK_MASK);
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (hit) q <= wdata;
      end
    end

    assign regs_flat[g*REG_W +: REG_W] = q;
  end
endmodule

// File: rtl/ecc_read_port.sv
module ecc_read_port
  import ecc_regbank_pkg::*;
#(
  parameter int NWORDS = 8,
  localparam int IDX_W = $clog2(NWORDS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic                    rd_fire,
  input  logic [IDX_W-1:0]        word_idx,
  input  logic [NWORDS*REG_W-1:0] regs_flat,
  output logic [REG_W-1:0]        rsp_rdata,
  output logic                    rsp_ready
);
  logic [REG_W-1:0] sel_word;
  assign sel_word = regs_flat[word_idx*REG_W +: REG_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_rdata <= '0;
      rsp_ready <= 1'b0;
    end else begin
      rsp_rdata <= rd_fire ? sel_word : '0;
      rsp_ready <= req_valid;
    end
  end
endmodule

// File: rtl/ecc_fault_regbank.sv
module ecc_fault_regbank
  import ecc_regbank_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NWORDS = 8,
  parameter int ID_W = 8,
  parameter logic [ID_W-1:0] IDENT = 8'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [REG_W-1:0]  req_wdata,
  output logic [REG_W-1:0]  rsp_rdata,
  output logic              rsp_ready
);
  localparam int IDX_W = $clog2(NWORDS);

  logic                    wr_fire;
  logic                    rd_fire;
  logic                    narrow_wr;
  logic [IDX_W-1:0]        word_idx;
  logic [NWORDS*REG_W-1:0] regs_flat;

  ecc_acc_decode #(.ADDR_W(ADDR_W), .NWORDS(NWORDS)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .wr_fire   (wr_fire),
    .rd_fire   (rd_fire),
    .narrow_wr (narrow_wr),
    .word_idx  (word_idx)
  );

  ecc_reg_store #(.NWORDS(NWORDS), .ID_W(ID_W), .IDENT(IDENT)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_fire   (wr_fire),
    .word_idx  (word_idx),
    .wdata     (req_wdata),
    .regs_flat (regs_flat)
  );

  ecc_read_port #(.NWORDS(NWORDS)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .rd_fire   (rd_fire),
    .word_idx  (word_idx),
    .regs_flat (regs_flat),
    .rsp_rdata (rsp_rdata),
    .rsp_ready (rsp_ready)
  );
endmodule

// File: rtl/ecc_fault_regbank_chk.sv
module ecc_fault_regbank_chk
  import ecc_regbank_pkg::*;
#(
  parameter int NWORDS = 8,
  parameter int ID_W = 8,
  parameter logic [ID_W-1:0] IDENT = 8'h10
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_valid,
  input logic                    req_write,
  input logic [1:0]              req_size,
  input logic                    narrow_wr,
  input logic [NWORDS*REG_W-1:0] regs_flat,
  input logic [REG_W-1:0]        rsp_rdata,
  input logic                    rsp_ready
);
  localparam logic [NWORDS*REG_W-1:0] RST_IMG =
    {{((NWORDS-1)*REG_W){1'b0}}, IDENT, {(REG_W-ID_W){1'b0}}};

  logic rst_seen = 1'b0;
  always_ff @(posedge clk) if (rst) rst_seen <= 1'b1;

  // R2
  assert_ident_locked_R2: assert property (@(posedge clk) disable iff (rst || !rst_seen)
    regs_flat[REG_W-1 -: ID_W] == IDENT);

  // R5
  assert_narrow_write_inert_R5: assert property (@(posedge clk) disable iff (rst || !rst_seen)
    narrow_wr |=> $stable(regs_flat));

  // R6
  assert_narrow_read_zero_R6: assert property (@(posedge clk) disable iff (rst || !rst_seen)
    (req_valid && !req_write && req_size != SZ_WORD) |=> rsp_rdata == '0);

  // R7
  assert_ready_follows_req_R7: assert property (@(posedge clk) disable iff (rst || !rst_seen)
    req_valid |=> rsp_ready);

  // R7
  assert_ready_idle_low_R7: assert property (@(posedge clk) disable iff (rst || !rst_seen)
    !req_valid |=> !rsp_ready);

  // R9
  assert_reset_image_R9: assert property (@(posedge clk)
    rst |=> (regs_flat == RST_IMG && !rsp_ready));
endmodule

bind ecc_fault_regbank ecc_fault_regbank_chk #(
  .NWORDS(NWORDS), .ID_W(ID_W), .IDENT(IDENT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_size  (req_size),
  .narrow_wr (narrow_wr),
  .regs_flat (regs_flat),
  .rsp_rdata (rsp_rdata),
  .rsp_ready (rsp_ready)
);

// File: tb/ecc_fault_regbank_bench.sv
module ecc_fault_regbank_bench;
  localparam logic [7:0] ID = 8'h10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = 2'b10;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        rsp_ready;

  always #2 clk = ~clk;  // 250 MHz

  ecc_fault_regbank #(.IDENT(ID)) u_ecc_fault_regbank (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_ready(rsp_ready)
  );

  typedef struct packed {
    logic [31:0] exp;
    logic [7:0]  rq;
  } item_t;

  item_t       sb[$];
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;
  logic [31:0] mdl[8];

  // Bench model of the reset image (R9).
  task automatic model_reset();
    mdl[0] = {ID, 24'h0};
    for (int i = 1; i < 8; i++) mdl[i] = '0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [1:0] sz,
                    input logic [31:0] d, input int rq);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
    if (sz == 2'b10) begin
      if (a[4:2] == 3'd0) mdl[0] = {mdl[0][31:24], d[23:0]};
      else mdl[a[4:2]] = d;
    end
    sb.push_back('{exp: 32'h0, rq: 8'(rq)});  // R6: writes reply with zero
  endtask

  task automatic rd(input logic [31:0] a, input logic [1:0] sz, input int rq);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
    sb.push_back('{exp: (sz == 2'b10) ? mdl[a[4:2]] : 32'h0, rq: 8'(rq)});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic check(input bit ok, input int rq, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d actual=%08h expected=%08h", rq, act, exp);
    end
  endtask

  // Monitor: pop one expected reply per ready pulse (R7, R8).
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && rsp_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, 7, {31'h0, rsp_ready}, 32'h0);  // R7: unexpected ready
        end else begin
          item_t it;
          it = sb.pop_front();
          check(rsp_rdata === it.exp, it.rq, rsp_rdata, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check(rsp_ready === 1'b0, 9, {31'h0, rsp_ready}, 32'h0);  // R9 ready low in reset
    rst = 1'b0;

    // R9: reset image through reads of all words
    for (int i = 0; i < 8; i++) rd(32'(i * 4), 2'b10, 9);
    idle(2);

    // R2/R3: identity field locked, low bits writable
    wr(32'h0, 2'b10, 32'hFFFF_FFFF, 3);
    rd(32'h0, 2'b10, 2);                      // R8: back-to-back read sees the write
    wr(32'h0, 2'b10, 32'h0000_0000, 3);
    rd(32'h0, 2'b10, 3);
    wr(32'h0, 2'b10, 32'hA5C0_0011, 3);       // bits 0 and 4 set
    rd(32'h0, 2'b10, 2);
    idle(1);

    // R4: distinct patterns in the other words
    for (int i = 1; i < 8; i++) wr(32'(i * 4), 2'b10, 32'hC0DE_0000 ^ (32'(i) * 32'h0101_1111), 4);
    for (int i = 1; i < 8; i++) rd(32'(i * 4), 2'b10, 4);
    idle(1);

    // R1: aliasing above 0x1F
    for (int i = 0; i < 8; i++) wr(32'h0000_0460 + 32'(i * 4), 2'b10, 32'h3300_0000 + 32'(i * 32'h11), 1);
    for (int i = 0; i < 8; i++) rd(32'hFFFF_FFE0 + 32'(i * 4), 2'b10, 1);
    rd(32'h0000_0023, 2'b10, 1);              // low bits ignored, word 0
    idle(1);

    // R5: narrow writes have no effect
    for (int i = 0; i < 8; i++) begin
      wr(32'(i * 4), 2'b00, 32'hFFFF_FFFF, 5);
      wr(32'(i * 4) + 32'h2, 2'b01, 32'hFFFF_FFFF, 5);
    end
    for (int i = 0; i < 8; i++) rd(32'(i * 4), 2'b10, 5);
    // R6: narrow reads return zero
    for (int i = 0; i < 8; i++) begin
      rd(32'(i * 4), 2'b00, 6);
      rd(32'(i * 4), 2'b01, 6);
    end
    idle(3);

    // R9: reset after a full fill keeps only the identity
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(rsp_ready === 1'b0, 9, {31'h0, rsp_ready}, 32'h0);
    rst = 1'b0;
    model_reset();
    for (int i = 0; i < 8; i++) rd(32'h100 + 32'(i * 4), 2'b10, 9);
    idle(3);

    check(sb.size() == 0, 7, 32'(sb.size()), 32'h0);  // R7: every request answered
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule